// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind a bit-level I2C shifter and judges the address phase of every transfer. The shifter reports START and STOP conditions and hands over each received byte with a one-cycle strobe. The recognizer compares the first byte after a START with a programmable own-address register, and answers with an ACK or NACK decision for the shifter to drive onto the bus.

It supports plain 7-bit addresses and an optional general-call match gated by one register bit. It also supports 10-bit addresses. For a 10-bit address, a header byte `11110xx` carries the two top address bits, and the following byte is compared against a second register.

A 10-bit match is confirmed in two steps. The header is acknowledged quietly. The slave-selected flag and the interrupt request rise only when the second byte also matches. The received R/W bit is kept and presented beside the selected flag. Software clears the interrupt with a dedicated input. A software-reset strobe returns the whole block to idle.

Top module: `i2c_addr_match`

## Requirements
- R1: After `rst`, `selected`, `irq`, `ack_vld`, `ack` and `rw_dir` are all 0, and the block waits for a START.
- R2: In the first byte after a START, bits [7:1] are compared with `own_addr[7:1]`, except when bits [7:3] are `11110` or bits [7:1] are all zero. If they are equal, the cycle after the strobe shows `ack_vld`=1 and `ack`=1. In that same cycle `selected` and `irq` become 1, and `rw_dir` takes bit 0 of the byte.
- R3: A first byte that matches nothing gives `ack_vld`=1 with `ack`=0. After that, bytes are ignored (no `ack_vld`) until the next START.
- R4: A first byte with bits [7:1] all zero is a general call. It is acknowledged and selects the slave only when `own_addr[0]`=1. Otherwise it gets a NACK and raises no interrupt.
- R5: A first byte with bits [7:3]=`11110` is a 10-bit header. Its bits [2:1] are compared with `own_addr[2:1]`. On a match it gets an ACK, `rw_dir` takes its bit 0, and neither `selected` nor `irq` rises. On a mismatch it gets a NACK.
- R6: The byte after an acknowledged header is compared with all 8 bits of `ext_addr`. If they are equal, it gets an ACK and `selected` and `irq` rise. If not, it gets a NACK and the block waits for START.
- R7: A STOP clears `selected` and abandons any partial match. A START also clears `selected` and restarts the address phase. This applies after a 10-bit header as well.
- R8: `ack_vld` is only produced for address bytes. Bytes before any START, or while the slave is selected, produce none.
- R9: `irq` stays at 1 until `irq_clr` is pulsed. A new selection in the same cycle as `irq_clr` leaves `irq` at 1.
- R10: A `soft_rst` pulse clears `selected`, `irq` and `rw_dir` and abandons any partial match. Later bytes are ignored until a START.
- R11: When `start_det` and `byte_vld` occur in the same cycle, the START wins and the byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset strobe |
| own_addr | input | 8 | Own address in [7:1], general-call enable in [0] |
| ext_addr | input | 8 | Low 8 bits of the 10-bit own address |
| start_det | input | 1 | START or repeated START seen |
| stop_det | input | 1 | STOP seen |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte, bit 7 first on the bus |
| irq_clr | input | 1 | Clears the interrupt request |
| ack_vld | output | 1 | An address decision is presented this cycle |
| ack | output | 1 | 1 = ACK, 0 = NACK; 0 when `ack_vld` is 0 |
| selected | output | 1 | Slave has been addressed |
| rw_dir | output | 1 | Captured R/W bit of the first address byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a 10-bit match caught halfway. That is the state after the header has been acknowledged but before the second byte arrives, and it shows nothing on `selected` or `irq`. The stimulus sends an acknowledged header and then, in the next cycle, injects a repeated START, a STOP or a software reset. It then offers the correct second byte and shows that the byte is treated as a fresh first byte or ignored. A behavioural reference model checked every cycle also covers coincident events: START together with a byte, and a new selection together with `irq_clr`.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

    localparam int BYTE_W = 8;
    localparam int HDR_W  = 5;
    localparam logic [HDR_W-1:0] TENBIT_HDR = 5'b11110;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND,
        PH_SEL
    } phase_t;

    typedef enum logic [1:0] {
        VD_NACK,
        VD_ACK_HOLD,
        VD_ACK_SEL
    } verdict_t;

    typedef struct packed {
        logic valid;
        logic ack;
    } reply_t;

    function automatic logic is_tenbit_hdr(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: HDR_W] == TENBIT_HDR;
    endfunction

    function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == '0;
    endfunction

endpackage

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
    import i2c_addr_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] ext_addr,
    output verdict_t     first_v,
    output logic         second_ok
);
    localparam int HI_BITS = 2;

    always_comb begin
        if (is_tenbit_hdr(rx_byte)) begin
            first_v = (rx_byte[HI_BITS:1] == own_addr[HI_BITS:1]) ? VD_ACK_HOLD : VD_NACK;
        end else if (is_gcall(rx_byte)) begin
            first_v = own_addr[0] ? VD_ACK_SEL : VD_NACK;
        end else begin
            first_v = (rx_byte[W-1:1] == own_addr[W-1:1]) ? VD_ACK_SEL : VD_NACK;
        end
    end

    assign second_ok = (rx_byte == ext_addr);

endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
    import i2c_addr_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rst,
    input  logic         start_det,
    input  logic         stop_det,
    input  logic         byte_vld,
    input  logic         rw_bit,
    input  verdict_t     first_v,
    input  logic         second_ok,
    output reply_t       reply,
    output logic         selected,
    output logic         rw_dir,
    output logic         sel_set
);
    phase_t phase_q;

    always_comb begin
        sel_set = 1'b0;
        if (!rst && !soft_rst && !start_det && !stop_det && byte_vld) begin
            sel_set = ((phase_q == PH_FIRST)  && (first_v == VD_ACK_SEL)) ||
                      ((phase_q == PH_SECOND) && second_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            phase_q  <= PH_IDLE;
            reply    <= '0;
            selected <= 1'b0;
            rw_dir   <= 1'b0;
        end else begin
            reply <= '0;
            if (start_det) begin
                phase_q  <= PH_FIRST;
                selected <= 1'b0;
            end else if (stop_det) begin
                phase_q  <= PH_IDLE;
                selected <= 1'b0;
            end else if (byte_vld) begin
                case (phase_q)
                    PH_FIRST: begin
                        reply.valid <= 1'b1;
                        case (first_v)
                            VD_ACK_SEL: begin
                                reply.ack <= 1'b1;
                                selected  <= 1'b1;
                                rw_dir    <= rw_bit;
                                phase_q   <= PH_SEL;
                            end
                            VD_ACK_HOLD: begin
                                reply.ack <= 1'b1;
                                rw_dir    <= rw_bit;
                                phase_q   <= PH_SECOND;
                            end
                            default: phase_q <= PH_IDLE;
                        endcase
                    end
                    PH_SECOND: begin
                        reply.valid <= 1'b1;
                        if (second_ok) begin
                            reply.ack <= 1'b1;
                            selected  <= 1'b1;
                            phase_q   <= PH_SEL;
                        end else begin
                            phase_q <= PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: while waiting for the second 10-bit byte the slave is never selected
    assert_tenbit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SECOND) |-> !selected);

    // R7: a STOP without a START deselects on the next edge
    assert_stop_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (stop_det && !start_det) |=> !selected);

    // R8: a decision only ever follows a byte strobe
    assert_reply_after_byte_R8: assert property (@(posedge clk) disable iff (rst)
        reply.valid |-> $past(byte_vld));

    // R11: a START takes precedence over a coincident byte
    assert_start_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (start_det && !soft_rst) |=> !reply.valid);

endmodule

// File: rtl/i2c_addr_irq.sv
module i2c_addr_irq (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            irq <= 1'b0;
        end else if (set_req) begin
            irq <= 1'b1;
        end else if (clr_req) begin
            irq <= 1'b0;
        end
    end

    // R9: the request holds until software clears it
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_req && !soft_rst) |=> irq);

    // R10: a software reset drops the request
    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !irq);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] ext_addr,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              irq_clr,
    output logic              ack_vld,
    output logic              ack,
    output logic              selected,
    output logic              rw_dir,
    output logic              irq
);
    verdict_t first_v;
    logic     second_ok;
    logic     sel_set;
    reply_t   reply;

    i2c_addr_cmp #(.W(BYTE_W)) u_cmp (
        .rx_byte  (byte_data),
        .own_addr (own_addr),
        .ext_addr (ext_addr),
        .first_v  (first_v),
        .second_ok(second_ok)
    );

    i2c_addr_fsm #(.W(BYTE_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .start_det(start_det),
        .stop_det (stop_det),
        .byte_vld (byte_vld),
        .rw_bit   (byte_data[0]),
        .first_v  (first_v),
        .second_ok(second_ok),
        .reply    (reply),
        .selected (selected),
        .rw_dir   (rw_dir),
        .sel_set  (sel_set)
    );

    i2c_addr_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .soft_rst(soft_rst),
        .set_req (sel_set),
        .clr_req (irq_clr),
        .irq     (irq)
    );

    assign ack_vld = reply.valid;
    assign ack     = reply.ack;

    // R2: every new selection comes with an interrupt request
    assert_sel_irq_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(selected) |-> irq);

    // R3: a NACK never coincides with a selection
    assert_nack_nosel_R3: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && !ack) |-> !selected);

endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic [7:0] ext_addr = 8'h00;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       irq_clr = 1'b0;
    logic       ack_vld, ack, selected, rw_dir, irq;

    always #4 clk = ~clk;

    i2c_addr_match u_i2c_addr_match (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .own_addr(own_addr), .ext_addr(ext_addr),
        .start_det(start_det), .stop_det(stop_det),
        .byte_vld(byte_vld), .byte_data(byte_data), .irq_clr(irq_clr),
        .ack_vld(ack_vld), .ack(ack), .selected(selected),
        .rw_dir(rw_dir), .irq(irq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model: waiting 0 = no START yet / gave up, 1 = expects first byte,
    // 2 = expects second 10-bit byte, 3 = addressed
    int m_wait = 0;
    bit m_ackv = 0, m_ack = 0, m_sel = 0, m_rw = 0, m_irq = 0;

    always @(posedge clk) begin
        bit nv, na, raise;
        nv = 0; na = 0; raise = 0;
        if (rst || soft_rst) begin
            m_wait = 0; m_sel = 0; m_rw = 0; m_irq = 0;
        end else begin
            if (start_det) begin
                m_wait = 1; m_sel = 0;
            end else if (stop_det) begin
                m_wait = 0; m_sel = 0;
            end else if (byte_vld && m_wait == 1) begin
                nv = 1;
                if (byte_data[7:3] == 5'b11110) begin
                    if (byte_data[2:1] == own_addr[2:1]) begin
                        na = 1; m_rw = byte_data[0]; m_wait = 2;
                    end else m_wait = 0;
                end else if (byte_data[7:1] == 7'd0) begin
                    if (own_addr[0]) begin
                        na = 1; raise = 1; m_rw = byte_data[0]; m_wait = 3; m_sel = 1;
                    end else m_wait = 0;
                end else if (byte_data[7:1] == own_addr[7:1]) begin
                    na = 1; raise = 1; m_rw = byte_data[0]; m_wait = 3; m_sel = 1;
                end else m_wait = 0;
            end else if (byte_vld && m_wait == 2) begin
                nv = 1;
                if (byte_data == ext_addr) begin
                    na = 1; raise = 1; m_wait = 3; m_sel = 1;
                end else m_wait = 0;
            end
            if (raise) m_irq = 1;
            else if (irq_clr) m_irq = 0;
        end
        m_ackv = nv; m_ack = na;
    end

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "model ack_vld", ack_vld, m_ackv);
            check(cur_req, "model ack", ack, m_ack);
            check(cur_req, "model selected", selected, m_sel);
            check(cur_req, "model rw_dir", rw_dir, m_rw);
            check(cur_req, "model irq", irq, m_irq);
        end
    end

    task automatic drive(input bit s, input bit p, input bit v, input logic [7:0] d,
                         input bit sr, input bit ic);
        start_det = s; stop_det = p; byte_vld = v; byte_data = d;
        soft_rst = sr; irq_clr = ic;
        @(negedge clk);
        start_det = 0; stop_det = 0; byte_vld = 0; byte_data = 8'h00;
        soft_rst = 0; irq_clr = 0;
    endtask

    task automatic start();             drive(1, 0, 0, 8'h00, 0, 0); endtask
    task automatic stop();              drive(0, 1, 0, 8'h00, 0, 0); endtask
    task automatic rx(input logic [7:0] d); drive(0, 0, 1, d, 0, 0); endtask
    task automatic clr();               drive(0, 0, 0, 8'h00, 0, 1); endtask

    task automatic report();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "selected", selected, 0);
        check("R1", "irq", irq, 0);
        check("R1", "ack_vld", ack_vld, 0);
        check("R1", "rw_dir", rw_dir, 0);

        // R8 byte before any START
        cur_req = "R8";
        own_addr = 8'hA0; ext_addr = 8'h3C;
        rx(8'hA0);
        check("R8", "ack_vld no start", ack_vld, 0);

        // R2 7-bit match, read direction
        cur_req = "R2";
        start(); rx(8'hA1);
        check("R2", "ack_vld", ack_vld, 1);
        check("R2", "ack", ack, 1);
        check("R2", "selected", selected, 1);
        check("R2", "irq", irq, 1);
        check("R2", "rw_dir", rw_dir, 1);

        // R8 data while selected
        cur_req = "R8";
        rx(8'hA0);
        check("R8", "ack_vld while selected", ack_vld, 0);

        // R9 irq holds, then clears
        cur_req = "R9";
        repeat (3) @(negedge clk);
        check("R9", "irq held", irq, 1);
        clr();
        check("R9", "irq cleared", irq, 0);

        // R7 STOP deselects
        cur_req = "R7";
        stop();
        check("R7", "selected after stop", selected, 0);

        // R3 mismatch then ignore
        cur_req = "R3";
        start(); rx(8'hB0);
        check("R3", "ack_vld", ack_vld, 1);
        check("R3", "ack", ack, 0);
        rx(8'hA0);
        check("R3", "ack_vld after nack", ack_vld, 0);
        check("R3", "selected after nack", selected, 0);

        // R4 general call disabled then enabled
        cur_req = "R4";
        start(); rx(8'h00);
        check("R4", "gcall off ack", ack, 0);
        check("R4", "gcall off irq", irq, 0);
        own_addr = 8'hA1;
        start(); rx(8'h00);
        check("R4", "gcall on ack", ack, 1);
        check("R4", "gcall on selected", selected, 1);
        check("R4", "gcall on irq", irq, 1);
        clr();

        // R5 / R6 10-bit match
        cur_req = "R5";
        own_addr = 8'h06; ext_addr = 8'h3C;
        start(); rx(8'hF6);
        check("R5", "header ack", ack, 1);
        check("R5", "header selected", selected, 0);
        check("R5", "header irq", irq, 0);
        cur_req = "R6";
        rx(8'h3C);
        check("R6", "second ack", ack, 1);
        check("R6", "second selected", selected, 1);
        check("R6", "second irq", irq, 1);
        check("R6", "rw_dir", rw_dir, 0);
        clr();

        // R5 header mismatch
        cur_req = "R5";
        start(); rx(8'hF2);
        check("R5", "header mismatch ack_vld", ack_vld, 1);
        check("R5", "header mismatch ack", ack, 0);

        // R6 second byte mismatch
        cur_req = "R6";
        start(); rx(8'hF7);
        check("R6", "rw captured", rw_dir, 1);
        rx(8'h3D);
        check("R6", "second mismatch ack", ack, 0);
        check("R6", "second mismatch selected", selected, 0);
        rx(8'h3C);
        check("R6", "after mismatch ignored", ack_vld, 0);

        // R7 repeated START and STOP abort a partial match
        cur_req = "R7";
        start(); rx(8'hF6); start(); rx(8'h3C);
        check("R7", "restart treats as first byte", ack, 0);
        check("R7", "restart no select", selected, 0);
        start(); rx(8'hF6); stop(); rx(8'h3C);
        check("R7", "stop abort ack_vld", ack_vld, 0);

        // R9 new selection wins over clear
        cur_req = "R9";
        start(); rx(8'hF6);
        drive(0, 0, 1, 8'h3C, 0, 1);
        check("R9", "set wins over clear", irq, 1);

        // R10 soft reset
        cur_req = "R10";
        drive(0, 0, 0, 8'h00, 1, 0);
        check("R10", "selected", selected, 0);
        check("R10", "irq", irq, 0);
        check("R10", "rw_dir", rw_dir, 0);
        start(); rx(8'hF6);
        drive(0, 0, 0, 8'h00, 1, 0);
        rx(8'h3C);
        check("R10", "partial abandoned", ack_vld, 0);

        // R11 START with simultaneous byte
        cur_req = "R11";
        drive(1, 0, 1, 8'h06, 0, 0);
        check("R11", "coincident byte ignored", ack_vld, 0);
        rx(8'h06);
        check("R11", "next byte is first", ack, 1);
        check("R11", "selected", selected, 1);

        repeat (2) @(negedge clk);
        report();
    end

endmodule